// File: doc/BRIEF.md
# Per-Queue Packet Ready Tracker

This block keeps, for every queue of a multi-queue buffer, a count of whole packets that have been stored and not yet drained. Words entering a queue may carry a start marker, an end marker or both. The block pairs each start with the end that follows it in the same queue and counts the result as one complete packet. Each read of a word that carries an end marker removes one packet from the count of the queue being read. The block stores no data: it sees only the queue numbers and the markers of write and read events.

A queue is reported ready while its count is non-zero. The block drives a flag for the queue currently selected on the read side. It also drives a full per-queue ready vector, and an 8-bit group view of that vector that a status bus can carry in place of almost-empty status when packet mode is active. Packet mode is meant for a buffer whose input and output ports are both 36 bits wide, so that one stored word holds one marked word. A partial reset of one queue clears that queue's count and its open-packet state.

Top module: `pkt_ready_tracker`

## Requirements
- R1: While rst_ni is low, every bit of pkt_rdy_vec_o, pkt_rdy_o and stat_o is 0.
- R2: Bit q of pkt_rdy_vec_o is 1 exactly when queue q holds at least one complete packet, and it changes in the cycle after the clock edge that samples the event causing the change.
- R3: A write to queue q with wr_eop_i=1 completes a packet when a start is open in q or when wr_sop_i=1 on the same word, and it leaves q with no open start. A write with wr_sop_i=1 and wr_eop_i=0 opens a start, and repeating it while a start is already open adds no packet.
- R4: A write with wr_eop_i=1 and wr_sop_i=0 to a queue that has no open start leaves that queue's count unchanged.
- R5: A read (rd_en_i=1) of queue q with rd_eop_i=1 lowers q's count by one; when the count is already 0 the read has no effect.
- R6: A write that completes a packet in queue q and a read with rd_eop_i=1 of the same queue in the same cycle leave q's count unchanged.
- R7: prst_en_i=1 clears the count and the open start of queue prst_qid_i, and it takes priority over any write or read to that queue in the same cycle.
- R8: pkt_rdy_o equals bit rd_qid_i of pkt_rdy_vec_o at all times, whether or not rd_en_i is high.
- R9: stat_o bit j equals pkt_rdy_vec_o bit stat_sel_i*8+j, with queues at or above NUM_Q reading as 0.
- R10: A queue's count saturates at 2**CNT_W-1 (15 by default): further completed packets are dropped, so 15 end-marked reads empty it.
- R11: A queue that sees no write, no read and no partial reset in a cycle keeps its ready bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write event valid |
| wr_qid_i | input | QID_W (5) | Queue written |
| wr_sop_i | input | 1 | Written word carries start marker |
| wr_eop_i | input | 1 | Written word carries end marker |
| rd_en_i | input | 1 | Read event valid |
| rd_qid_i | input | QID_W (5) | Queue selected on the read side |
| rd_eop_i | input | 1 | Word read carries end marker |
| prst_en_i | input | 1 | Partial reset of one queue |
| prst_qid_i | input | QID_W (5) | Queue to partially reset |
| stat_sel_i | input | SEL_W (2) | Group of 8 queues shown on stat_o |
| pkt_rdy_o | output | 1 | Ready flag of queue rd_qid_i |
| pkt_rdy_vec_o | output | NUM_Q (32) | Ready flag of every queue |
| stat_o | output | GRP_W (8) | Ready flags of the selected group |

## Verification
Directed sequences cover a start and end on separate words, a single word carrying both markers, a repeated start, an end with no open start, and an end-marked read against a zero count; each separates pairing of markers from plain counting of end markers. A collision case places a completing write and an end-marked read on the same queue in one cycle, and a partial reset lands together with a write on its queue, which tells apart the priority and cancellation rules. A saturation run and sweeps of the read selector and the group selector follow, and a stretch of random events confined to four queues forces frequent collisions, all compared every cycle against a count-based model.

// File: rtl/prt_pkg.sv
package prt_pkg;
  typedef struct packed {
    logic wr_hit;
    logic sop;
    logic eop;
    logic rd_eop_hit;
    logic clr;
  } slot_ev_t;
endpackage

// File: rtl/prt_slot.sv
module prt_slot
  import prt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  slot_ev_t ev_i,
  output logic     rdy_o
);
  localparam logic [CNT_W-1:0] CntMax = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             open_q, open_d;
  logic             close;

  // an end marker closes a packet only if a start is open or on the same word
  assign close = ev_i.wr_hit && ev_i.eop && (open_q || ev_i.sop);

  always_comb begin
    open_d = open_q;
    if (ev_i.wr_hit) begin
      if (ev_i.eop)      open_d = 1'b0;
      else if (ev_i.sop) open_d = 1'b1;
    end
    if (ev_i.clr) open_d = 1'b0;
  end

  always_comb begin
    cnt_d = cnt_q;
    if (ev_i.clr) begin
      cnt_d = '0;
    end else if (close && ev_i.rd_eop_hit) begin
      cnt_d = cnt_q;
    end else if (close) begin
      if (cnt_q != CntMax) cnt_d = cnt_q + 1'b1;
    end else if (ev_i.rd_eop_hit && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      open_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      open_q <= open_d;
    end
  end

  assign rdy_o = (cnt_q != '0);
endmodule

// File: rtl/prt_grp_mux.sv
module prt_grp_mux #(
  parameter int NUM_Q   = 32,
  parameter int GRP_W   = 8,
  parameter int GRP_CNT = 4,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_Q-1:0] vec_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [GRP_W-1:0] grp_o
);
  localparam int PadW = GRP_CNT * GRP_W;

  logic [PadW-1:0] pad_vec;

  generate
    if (PadW > NUM_Q) begin : g_pad
      assign pad_vec = {{(PadW-NUM_Q){1'b0}}, vec_i};
    end else begin : g_nopad
      assign pad_vec = vec_i;
    end
  endgenerate

  always_comb begin
    grp_o = '0;
    for (int g = 0; g < GRP_CNT; g++) begin
      if (int'(sel_i) == g) grp_o = pad_vec[g*GRP_W +: GRP_W];
    end
  end
endmodule

// File: rtl/pkt_ready_tracker.sv
module pkt_ready_tracker
  import prt_pkg::*;
#(
  parameter int NUM_Q   = 32,
  parameter int CNT_W   = 4,
  parameter int GRP_W   = 8,
  localparam int QID_W   = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int GRP_CNT = (NUM_Q + GRP_W - 1) / GRP_W,
  localparam int SEL_W   = (GRP_CNT > 1) ? $clog2(GRP_CNT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [QID_W-1:0] wr_qid_i,
  input  logic             wr_sop_i,
  input  logic             wr_eop_i,
  input  logic             rd_en_i,
  input  logic [QID_W-1:0] rd_qid_i,
  input  logic             rd_eop_i,
  input  logic             prst_en_i,
  input  logic [QID_W-1:0] prst_qid_i,
  input  logic [SEL_W-1:0] stat_sel_i,
  output logic             pkt_rdy_o,
  output logic [NUM_Q-1:0] pkt_rdy_vec_o,
  output logic [GRP_W-1:0] stat_o
);
  slot_ev_t ev [NUM_Q];

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
      assign ev[q].wr_hit     = wr_en_i && (wr_qid_i == QID_W'(q));
      assign ev[q].sop        = wr_sop_i;
      assign ev[q].eop        = wr_eop_i;
      assign ev[q].rd_eop_hit = rd_en_i && rd_eop_i && (rd_qid_i == QID_W'(q));
      assign ev[q].clr        = prst_en_i && (prst_qid_i == QID_W'(q));

      prt_slot #(.CNT_W(CNT_W)) i_slot (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .ev_i  (ev[q]),
        .rdy_o (pkt_rdy_vec_o[q])
      );
    end
  endgenerate

  always_comb begin
    pkt_rdy_o = 1'b0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (rd_qid_i == QID_W'(q)) pkt_rdy_o = pkt_rdy_vec_o[q];
    end
  end

  prt_grp_mux #(
    .NUM_Q  (NUM_Q),
    .GRP_W  (GRP_W),
    .GRP_CNT(GRP_CNT),
    .SEL_W  (SEL_W)
  ) i_grp_mux (
    .vec_i(pkt_rdy_vec_o),
    .sel_i(stat_sel_i),
    .grp_o(stat_o)
  );
endmodule

// File: rtl/pkt_ready_tracker_chk.sv
module pkt_ready_tracker_chk #(
  parameter int NUM_Q = 32,
  parameter int QID_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [QID_W-1:0] wr_qid_i,
  input logic             wr_eop_i,
  input logic             rd_en_i,
  input logic [QID_W-1:0] rd_qid_i,
  input logic             rd_eop_i,
  input logic             prst_en_i,
  input logic [QID_W-1:0] prst_qid_i,
  input logic             pkt_rdy_o,
  input logic [NUM_Q-1:0] pkt_rdy_vec_o
);
  logic [NUM_Q-1:0] wr_mask, rd_mask, pr_mask, any_mask;
  logic [NUM_Q-1:0] prev_vec, prev_wr, prev_rd, prev_pr, prev_any;

  always_comb begin
    wr_mask = '0;
    rd_mask = '0;
    pr_mask = '0;
    any_mask = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      wr_mask[q]  = wr_en_i && wr_eop_i && (wr_qid_i == QID_W'(q));
      rd_mask[q]  = rd_en_i && rd_eop_i && (rd_qid_i == QID_W'(q));
      pr_mask[q]  = prst_en_i && (prst_qid_i == QID_W'(q));
      any_mask[q] = (wr_en_i && (wr_qid_i == QID_W'(q))) || rd_mask[q] || pr_mask[q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_vec <= '0;
      prev_wr  <= '0;
      prev_rd  <= '0;
      prev_pr  <= '0;
      prev_any <= '0;
    end else begin
      prev_vec <= pkt_rdy_vec_o;
      prev_wr  <= wr_mask;
      prev_rd  <= rd_mask;
      prev_pr  <= pr_mask;
      prev_any <= any_mask;
    end
  end

  // R2
  a_r2_rise_needs_eop_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_rdy_vec_o & ~prev_vec & ~prev_wr) == '0);

  // R5
  a_r5_fall_needs_read_or_prst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (~pkt_rdy_vec_o & prev_vec & ~(prev_rd | prev_pr)) == '0);

  // R7
  a_r7_prst_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_rdy_vec_o & prev_pr) == '0);

  // R11
  a_r11_idle_queue_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pkt_rdy_vec_o ^ prev_vec) & ~prev_any) == '0);

  // R8
  a_r8_sel_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_rdy_o == pkt_rdy_vec_o[rd_qid_i]);

  // R1
  always_comb begin
    if (!rst_ni) a_r1_reset_clear: assert (pkt_rdy_vec_o == '0);
  end
endmodule

bind pkt_ready_tracker pkt_ready_tracker_chk #(.NUM_Q(NUM_Q), .QID_W(QID_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_en_i      (wr_en_i),
  .wr_qid_i     (wr_qid_i),
  .wr_eop_i     (wr_eop_i),
  .rd_en_i      (rd_en_i),
  .rd_qid_i     (rd_qid_i),
  .rd_eop_i     (rd_eop_i),
  .prst_en_i    (prst_en_i),
  .prst_qid_i   (prst_qid_i),
  .pkt_rdy_o    (pkt_rdy_o),
  .pkt_rdy_vec_o(pkt_rdy_vec_o)
);

// File: tb/test_pkt_ready_tracker.sv
`timescale 1ns/1ps
module test_pkt_ready_tracker;
  localparam int NQ = 32;
  localparam int CMAX = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_sop = 0, wr_eop = 0, rd_en = 0, rd_eop = 0, prst_en = 0;
  logic [4:0] wr_qid = '0, rd_qid = '0, prst_qid = '0;
  logic [1:0] stat_sel = '0;
  logic pkt_rdy;
  logic [NQ-1:0] vec;
  logic [7:0] stat;

  int n_chk = 0, n_fail = 0;
  int m_cnt [NQ];
  bit m_open [NQ];
  string phase = "R1";
  bit done = 0;

  always #2 clk = ~clk;

  pkt_ready_tracker i_pkt_ready_tracker (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_qid_i(wr_qid), .wr_sop_i(wr_sop), .wr_eop_i(wr_eop),
    .rd_en_i(rd_en), .rd_qid_i(rd_qid), .rd_eop_i(rd_eop),
    .prst_en_i(prst_en), .prst_qid_i(prst_qid), .stat_sel_i(stat_sel),
    .pkt_rdy_o(pkt_rdy), .pkt_rdy_vec_o(vec), .stat_o(stat)
  );

  // behavioural model
  always @(posedge clk) begin
    if (rst_n) begin
      bit closed;
      bit drained;
      int wq;
      int rq;
      wq = int'(wr_qid);
      rq = int'(rd_qid);
      closed = wr_en && wr_eop && (m_open[wq] || wr_sop);
      drained = rd_en && rd_eop;
      if (wr_en) begin
        if (wr_eop) m_open[wq] = 0;
        else if (wr_sop) m_open[wq] = 1;
      end
      if (closed && drained && wq == rq) begin
        // no change
      end else begin
        if (closed && m_cnt[wq] < CMAX) m_cnt[wq]++;
        if (drained && m_cnt[rq] > 0) m_cnt[rq]--;
      end
      if (prst_en) begin
        m_cnt[int'(prst_qid)] = 0;
        m_open[int'(prst_qid)] = 0;
      end
    end
  end

  function automatic logic [NQ-1:0] exp_vec();
    logic [NQ-1:0] v;
    for (int q = 0; q < NQ; q++) v[q] = (m_cnt[q] != 0);
    return v;
  endfunction

  task automatic check(input string tag, input logic [NQ-1:0] act, input logic [NQ-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, before inputs move
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NQ-1:0] ev;
      ev = exp_vec();
      check({phase, " vec R2"}, vec, ev);
      check({phase, " sel R8"}, NQ'(pkt_rdy), NQ'(ev[rd_qid]));
      check({phase, " grp R9"}, NQ'(stat), NQ'(ev[int'(stat_sel)*8 +: 8]));
    end
  end

  task automatic cyc(input bit we, input int wq, input bit ws, input bit wee,
                     input bit re, input int rq, input bit ree,
                     input bit pe, input int pq);
    @(negedge clk);
    #1;
    wr_en = we; wr_qid = 5'(wq); wr_sop = ws; wr_eop = wee;
    rd_en = re; rd_qid = 5'(rq); rd_eop = ree;
    prst_en = pe; prst_qid = 5'(pq);
  endtask

  task automatic wr(input int q, input bit s, input bit e);
    cyc(1, q, s, e, 0, int'(rd_qid), 0, 0, 0);
  endtask

  task automatic rd(input int q, input bit e);
    cyc(0, 0, 0, 0, 1, q, e, 0, 0);
  endtask

  task automatic idle();
    cyc(0, 0, 0, 0, 0, int'(rd_qid), 0, 0, 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int q = 0; q < NQ; q++) begin m_cnt[q] = 0; m_open[q] = 0; end
    #9;
    check("R1 reset vec", vec, '0);
    check("R1 reset flags", NQ'({pkt_rdy, stat}), '0);
    @(negedge clk);
    rst_n = 1;

    phase = "R3 sop-eop";
    rd_qid = 5'd3;
    wr(3, 1, 0); wr(3, 0, 0); wr(3, 0, 0); wr(3, 0, 1); idle();
    phase = "R3 single word";
    wr(5, 1, 1); idle();
    phase = "R3 repeated sop";
    wr(6, 1, 0); wr(6, 1, 0); wr(6, 0, 1); wr(6, 0, 1); idle();

    phase = "R4 orphan eop";
    wr(7, 0, 1); idle(); wr(3, 0, 1); idle();

    phase = "R5 drain";
    rd(3, 0); rd(3, 1); idle(); rd(3, 1); idle(); rd(6, 1); idle();

    phase = "R6 same cycle";
    wr(9, 1, 1); wr(9, 1, 0);
    cyc(1, 9, 0, 1, 1, 9, 1, 0, 0); idle();
    cyc(1, 9, 1, 1, 1, 9, 1, 0, 0); idle();
    rd(9, 1); idle();
    phase = "R6 other queues";
    wr(10, 1, 0);
    cyc(1, 10, 0, 1, 1, 5, 1, 0, 0); idle();

    phase = "R7 partial reset";
    wr(11, 1, 1); wr(11, 1, 1); wr(11, 1, 0);
    cyc(1, 11, 0, 1, 0, 11, 0, 1, 11); idle();
    wr(11, 0, 1); idle();
    wr(12, 1, 0); cyc(0, 0, 0, 0, 0, 12, 0, 1, 12); wr(12, 0, 1); idle();

    phase = "R10 saturate";
    for (int i = 0; i < 17; i++) wr(20, 1, 1);
    for (int i = 0; i < 14; i++) rd(20, 1);
    idle(); rd(20, 1); idle();

    phase = "R8 selector";
    wr(0, 1, 1); wr(8, 1, 1); wr(31, 1, 1); wr(17, 1, 1);
    for (int q = 0; q < NQ; q++) cyc(0, 0, 0, 0, 0, q, 1, 0, 0);

    phase = "R9 group";
    for (int g = 0; g < 4; g++) begin
      stat_sel = 2'(g);
      idle();
    end

    phase = "R11 mixed random";
    for (int i = 0; i < 400; i++) begin
      stat_sel = 2'($urandom_range(3));
      cyc($urandom_range(1), $urandom_range(3), $urandom_range(1), $urandom_range(1),
          $urandom_range(1), $urandom_range(3), $urandom_range(1),
          ($urandom_range(15) == 0), $urandom_range(3));
    end
    idle(); idle();
    finish_run();
  end
endmodule